// File: doc/BRIEF.md
# Transactional Line-State Array with Flash Commit and Abort

This block holds a six-bit state word for every line of a cache and lets a whole transaction be committed or aborted in two cycles, however many lines the transaction touched. Each word carries a transactional flag, an alert flag, a two-bit coherence code, an outcome bit that records how the last transaction ended, and a speculative-write marker. A line is written and read one at a time through an access port. A read returns the line's decoded state one cycle later.

Ending a transaction starts a short sequence. The sequencer leaves its idle state `SQ_IDLE` when an end request arrives, then spends one cycle in `SQ_BCAST` and one in `SQ_FLASH` before returning to `SQ_IDLE`. In `SQ_BCAST` the outcome bit is driven into every line whose transactional flag is set, and into no other line. In `SQ_FLASH` the transactional and alert flags of all lines are cleared. The sequencer takes no other transitions.

Lines that held speculative writes are not rewritten during the sequence. Their final state is worked out the next time they are read. A line that has lost its transactional flag, holds the code M, has its speculative-write marker set and recorded an abort is reported as invalid. On that read its code is rewritten to I and its marker is cleared. A separate input clears the alert flag of every line at once.

Top module: `ftag_array`

## Requirements
- R1: After reset, every line reads as class I (code 0) with its alert flag at 0, and `busy` is 0.
- R2: A write access sets the addressed line to the class and alert value given. A read access accepted on a clock edge raises `rd_valid` for exactly one cycle after that edge, with that line's class and alert flag. A write produces no `rd_valid`.
- R3: Class codes on `acc_class` and `rd_class` are: I=0, S=1, E=2, M=3, TI=4, TS=5, TE=6, TM=7, TMI=8. Codes 9 to 15 written to a line are stored as I.
- R4: An `end_req` accepted while idle holds `busy` high for exactly the two following cycles. Any access presented while `busy` is high is ignored: a write there changes no line, and a read there raises no `rd_valid`.
- R5: After a commit (`end_outcome`=1), lines that were TMI read M, TM read M, TE read E, TS read S and TI read I.
- R6: After an abort (`end_outcome`=0), lines that were TMI or TI read I, and TM, TE and TS read M, E and S.
- R7: After either outcome, every alert flag reads 0. A line that was not transactional when the sequence began keeps its class; in particular, a line that became M by a commit still reads M after a later abort.
- R8: A read of a line left stale by an aborted speculative write reports I. The read rewrites the line to the plain I state, and the line keeps reading I after later transaction ends.
- R9: `alert_clr` asserted while idle clears the alert flag of every line and changes no class.
- R10: When an access and `end_req` arrive in the same idle cycle, the access takes effect first, and the sequence then acts on the updated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Single-line access request |
| acc_write | input | 1 | 1 = write the line, 0 = read the line |
| acc_idx | input | IDXW | Line index |
| acc_class | input | 4 | Class to write (R3 codes) |
| acc_alert | input | 1 | Alert flag to write |
| end_req | input | 1 | Start the commit/abort sequence |
| end_outcome | input | 1 | 1 = commit, 0 = abort |
| alert_clr | input | 1 | Clear every alert flag |
| busy | output | 1 | Sequence in progress; accesses ignored |
| rd_valid | output | 1 | Read result valid |
| rd_class | output | 4 | Decoded class of the line read (R3 codes) |
| rd_alert | output | 1 | Alert flag of the line read |

## Verification
The bench builds the array with NLINES=8, instead of the default 16. With fewer lines, random writes, transaction ends and reads land on the same lines often. This produces stale lines from aborts that are read back after one or more later transaction ends. It also produces lines that were committed to M and then sit through an abort. Directed cases add the remaining corners: accesses presented during both busy cycles, an access arriving in the same cycle as an end request, and an alert clear that must leave every class unchanged.

// File: rtl/ftag_pkg.sv
package ftag_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_e;

    // Six-bit line word
    typedef struct packed {
        logic  t;     // transactional
        logic  a;     // alert
        mesi_e mesi;  // coherence code
        logic  ca;    // last outcome: 1 commit, 0 abort
        logic  mi;    // held a speculative write
    } tag_s;

    typedef enum logic [3:0] {
        CL_I   = 4'd0,
        CL_S   = 4'd1,
        CL_E   = 4'd2,
        CL_M   = 4'd3,
        CL_TI  = 4'd4,
        CL_TS  = 4'd5,
        CL_TE  = 4'd6,
        CL_TM  = 4'd7,
        CL_TMI = 4'd8
    } cls_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BCAST = 2'd1,
        SQ_FLASH = 2'd2
    } seq_e;

    function automatic logic is_stale(input tag_s w);
        return !w.t && (w.mesi == MESI_M) && !w.ca && w.mi;
    endfunction

    function automatic cls_e decode(input tag_s w);
        cls_e c;
        if (w.t) begin
            unique case (w.mesi)
                MESI_I:  c = CL_TI;
                MESI_S:  c = CL_TS;
                MESI_E:  c = CL_TE;
                default: c = w.mi ? CL_TMI : CL_TM;
            endcase
        end else if (is_stale(w)) begin
            c = CL_I;
        end else begin
            unique case (w.mesi)
                MESI_I:  c = CL_I;
                MESI_S:  c = CL_S;
                MESI_E:  c = CL_E;
                default: c = CL_M;
            endcase
        end
        return c;
    endfunction

    // Build a line word for a written class; the outcome bit is kept.
    function automatic tag_s encode(input logic [3:0] c, input logic al, input logic ca_keep);
        tag_s w;
        w.a  = al;
        w.ca = ca_keep;
        w.mi = 1'b0;
        unique case (c)
            4'd1:    begin w.t = 1'b0; w.mesi = MESI_S; end
            4'd2:    begin w.t = 1'b0; w.mesi = MESI_E; end
            4'd3:    begin w.t = 1'b0; w.mesi = MESI_M; end
            4'd4:    begin w.t = 1'b1; w.mesi = MESI_I; end
            4'd5:    begin w.t = 1'b1; w.mesi = MESI_S; end
            4'd6:    begin w.t = 1'b1; w.mesi = MESI_E; end
            4'd7:    begin w.t = 1'b1; w.mesi = MESI_M; end
            4'd8:    begin w.t = 1'b1; w.mesi = MESI_M; w.mi = 1'b1; end
            default: begin w.t = 1'b0; w.mesi = MESI_I; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ftag_seq.sv
module ftag_seq
    import ftag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic end_req,
    input  logic end_outcome,
    output logic busy,
    output logic bcast_en,
    output logic flash_en,
    output logic outcome_q
);

    seq_e st_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SQ_IDLE;
            outcome_q <= 1'b0;
        end else begin
            unique case (st_q)
                SQ_IDLE: if (end_req) begin
                    st_q      <= SQ_BCAST;
                    outcome_q <= end_outcome;
                end
                SQ_BCAST: st_q <= SQ_FLASH;
                SQ_FLASH: st_q <= SQ_IDLE;
                default:  st_q <= SQ_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = 1'b0;
        bcast_en = 1'b0;
        flash_en = 1'b0;
        unique case (st_q)
            SQ_IDLE:  ;
            SQ_BCAST: begin busy = 1'b1; bcast_en = 1'b1; end
            SQ_FLASH: begin busy = 1'b1; flash_en = 1'b1; end
            default:  ;
        endcase
    end

    // R4
    seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_IDLE && end_req) |=> bcast_en);
    // R4
    seq_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_en |=> (flash_en && !bcast_en));
    // R4
    seq_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_en |=> !busy);

endmodule

// File: rtl/ftag_line.sv
module ftag_line
    import ftag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  tag_s wr_tag,
    input  logic fix_en,
    input  logic bcast_en,
    input  logic outcome,
    input  logic flash_en,
    input  logic alert_clr,
    output tag_s q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr_en) begin
                q <= wr_tag;
            end else if (fix_en) begin
                q.mesi <= MESI_I;
                q.mi   <= 1'b0;
            end
            if (bcast_en && q.t) q.ca <= outcome;
            if (flash_en) begin
                q.t <= 1'b0;
                q.a <= 1'b0;
            end
            if (alert_clr) q.a <= 1'b0;
        end
    end

    // R7
    no_stray_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_en && !q.t) |=> $stable(q.ca));
    // R5
    flash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_en |=> (!q.t && !q.a));
    // R8
    fixup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> (q.mesi == MESI_I && !q.mi));

endmodule

// File: rtl/ftag_array.sv
module ftag_array
    import ftag_pkg::*;
#(
    parameter int NLINES = 16,
    localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [IDXW-1:0] acc_idx,
    input  logic [3:0]      acc_class,
    input  logic            acc_alert,
    input  logic            end_req,
    input  logic            end_outcome,
    input  logic            alert_clr,
    output logic            busy,
    output logic            rd_valid,
    output logic [3:0]      rd_class,
    output logic            rd_alert
);

    logic bcast_en, flash_en, outcome_q;
    tag_s line_q [NLINES];
    tag_s sel;
    tag_s wr_tag;
    logic acc_ok;

    ftag_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .end_req    (end_req),
        .end_outcome(end_outcome),
        .busy       (busy),
        .bcast_en   (bcast_en),
        .flash_en   (flash_en),
        .outcome_q  (outcome_q)
    );

    assign acc_ok = acc_valid && !busy;
    assign sel    = line_q[acc_idx];
    assign wr_tag = encode(acc_class, acc_alert, sel.ca);

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic hit;
        assign hit = acc_ok && (acc_idx == IDXW'(i));
        ftag_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (hit && acc_write),
            .wr_tag   (wr_tag),
            .fix_en   (hit && !acc_write && is_stale(sel)),
            .bcast_en (bcast_en),
            .outcome  (outcome_q),
            .flash_en (flash_en),
            .alert_clr(alert_clr && !busy),
            .q        (line_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_class <= CL_I;
            rd_alert <= 1'b0;
        end else begin
            rd_valid <= acc_ok && !acc_write;
            if (acc_ok && !acc_write) begin
                rd_class <= decode(sel);
                rd_alert <= sel.a;
            end
        end
    end

    // R2
    rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write && !busy));
    // R4
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc_valid) |=> !rd_valid);

endmodule

// File: tb/ftag_array_tb.sv
module ftag_array_tb_top;

    localparam int NL = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0, acc_alert = 0;
    logic [IW-1:0] acc_idx = '0;
    logic [3:0] acc_class = '0;
    logic end_req = 0, end_outcome = 0, alert_clr = 0;
    logic busy, rd_valid, rd_alert;
    logic [3:0] rd_class;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [3:0] m_cls [NL];
    logic       m_al  [NL];

    always #10 clk = ~clk;

    ftag_array #(.NLINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_idx(acc_idx), .acc_class(acc_class), .acc_alert(acc_alert),
        .end_req(end_req), .end_outcome(end_outcome), .alert_clr(alert_clr),
        .busy(busy), .rd_valid(rd_valid), .rd_class(rd_class), .rd_alert(rd_alert)
    );

    function automatic logic [3:0] after_end(input logic [3:0] c, input logic ok);
        case (c)
            4'd8:    return ok ? 4'd3 : 4'd0;
            4'd7:    return 4'd3;
            4'd6:    return 4'd2;
            4'd5:    return 4'd1;
            4'd4:    return 4'd0;
            default: return c;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int i, input logic [3:0] c, input logic al);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_idx = IW'(i); acc_class = c; acc_alert = al;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        check("R2 no rd_valid on write", rd_valid, 0);
        m_cls[i] = (c > 4'd8) ? 4'd0 : c;
        m_al[i]  = al;
    endtask

    task automatic do_read(input int i, input string req);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_idx = IW'(i);
        @(negedge clk);
        acc_valid = 0;
        check(req, rd_valid, 1);
        check(req, rd_class, m_cls[i]);
        check(req, rd_alert, m_al[i]);
    endtask

    task automatic end_txn(input logic ok);
        @(negedge clk);
        end_req = 1; end_outcome = ok;
        @(negedge clk);
        end_req = 0;
        check("R4 busy first cycle", busy, 1);
        acc_valid = 1; acc_write = 1; acc_idx = '0; acc_class = 4'd1; acc_alert = 1;
        @(negedge clk);
        check("R4 busy second cycle", busy, 1);
        acc_write = 0;
        @(negedge clk);
        acc_valid = 0;
        check("R4 busy released", busy, 0);
        check("R4 read during busy ignored", rd_valid, 0);
        for (int k = 0; k < NL; k++) begin
            m_cls[k] = after_end(m_cls[k], ok);
            m_al[k]  = 0;
        end
    endtask

    task automatic do_aclr();
        @(negedge clk);
        alert_clr = 1;
        @(negedge clk);
        alert_clr = 0;
        for (int k = 0; k < NL; k++) m_al[k] = 0;
    endtask

    initial begin
        for (int k = 0; k < NL; k++) begin m_cls[k] = 0; m_al[k] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        for (int k = 0; k < NL; k++) do_read(k, "R1 reset line");

        // R3 every class code round trip, plus an out-of-range code
        for (int k = 0; k < NL; k++) do_write(k, 4'(k + 1), k[0]);
        for (int k = 0; k < NL; k++) do_read(k, "R3 class code");
        do_write(0, 4'd12, 1);
        do_read(0, "R3 code 12 stored as I");

        // R5 commit
        do_write(0, 4'd8, 1); do_write(1, 4'd4, 0); do_write(2, 4'd7, 1);
        end_txn(1);
        do_read(0, "R5 TMI commit to M");
        do_read(1, "R5 TI commit to I");
        do_read(2, "R5 TM commit to M");

        // R6 and R7: committed M untouched by later abort
        do_write(3, 4'd8, 0); do_write(4, 4'd6, 1);
        end_txn(0);
        do_read(0, "R7 committed M survives abort");
        do_read(3, "R6 TMI abort to I");
        do_read(4, "R6 TE abort to E");
        do_read(4, "R7 alert cleared");

        // R8 stale line read, then more transaction ends
        do_write(5, 4'd8, 0);
        end_txn(0);
        do_read(5, "R8 stale read as I");
        end_txn(1);
        do_read(5, "R8 stays I after commit");

        // R8 stale line left unread across a commit
        do_write(6, 4'd8, 1);
        end_txn(0);
        end_txn(1);
        do_read(6, "R8 unread stale stays I");

        // R9 alert clear
        do_write(1, 4'd2, 1); do_write(2, 4'd5, 1);
        do_aclr();
        do_read(1, "R9 alert clear E");
        do_read(2, "R9 alert clear TS");

        // R10 access with end_req in the same cycle
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_idx = 3'd7; acc_class = 4'd8; acc_alert = 1;
        end_req = 1; end_outcome = 1;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; end_req = 0;
        check("R10 busy", busy, 1);
        repeat (2) @(negedge clk);
        m_cls[7] = 4'd3; m_al[7] = 0;
        do_read(7, "R10 write then commit");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom_range(99));
            if (op < 45)      do_write(int'($urandom_range(NL-1)), 4'($urandom_range(8)), 1'($urandom_range(1)));
            else if (op < 85) do_read(int'($urandom_range(NL-1)), "R2 random read");
            else if (op < 96) end_txn(1'($urandom_range(1)));
            else              do_aclr();
        end
        for (int k = 0; k < NL; k++) do_read(k, "R2 final sweep");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule